// File: doc/BRIEF.md
# Sound Generator Control Register File

This block is the write side of a four-channel square-wave and noise sound generator. A host writes single bytes over a write-only 8-bit port. The block keeps every control value the sound engines need: one attenuation value for each of the four channels, a period for each of the three tone channels, and a small control field for the noise channel. All of these values are driven out in parallel, so the tone, noise and mixing logic downstream reads them directly.

Bytes come in two kinds. A selecting byte picks a target register and loads its low bits. A continuation byte carries no address. It goes to whichever register was last selected, and the selection survives any number of continuation bytes. For a tone period, a continuation byte fills the upper part of the period. For the narrower registers, it replaces the low bits. When a byte changes the noise control field, the block also sends a one-cycle pulse so that the noise engine can restart its shift register.

Top module: `psgr_regs`

## Requirements
- R1: While `rst` is high at a rising edge, all four attenuation values become 0xF, all three tone periods become 0, the noise field becomes 0, `noise_reset` is low, and the selection points at channel 0's tone period.
- R2: A written byte with bit 7 = 1 is a selecting byte. Bits 6:5 give the channel (0..3). Bit 4 = 1 picks that channel's attenuation and bit 4 = 0 picks its tone period (channels 0..2) or the noise field (channel 3). Bits 3:0 load the low four bits of the picked register.
- R3: A byte with bit 7 = 0 is a continuation byte. When a tone period is selected, its bits 5:0 load period bits 9:4 and period bits 3:0 keep their value. Bit 6 is ignored.
- R4: A continuation byte to a selected attenuation loads bits 3:0 of the byte. Bits 6:4 are ignored.
- R5: The noise field is 3 bits wide. Both byte kinds load it from bits 2:0 of the byte, and byte bit 3 is discarded.
- R6: Continuation bytes never change the selection. Several in a row, with or without idle cycles between them, all go to the same register.
- R7: Every accepted byte shows on the outputs in the cycle after the edge that took it. A tone period shows its partly updated value after a selecting byte alone.
- R8: `noise_reset` is high for exactly the one cycle after each accepted byte that targets the noise field, of either kind, and is low at all other times.
- R9: While `wr_en` is low at an edge, no output register changes.
- R10: An accepted byte changes at most the one register it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte strobe, one byte taken on each edge where it is high |
| wr_data | input | 8 | Written byte |
| att_flat | output | 16 | Attenuation values, channel n at bits 4n+3:4n |
| tone_flat | output | 30 | Tone periods, channel n at bits 10n+9:10n |
| noise_ctrl | output | 3 | Noise control field |
| noise_reset | output | 1 | One-cycle pulse after each noise field write |

## Verification
The hardest case to reach is a continuation byte that lands in the noise field or in an attenuation value a long time after its selecting byte, with idle cycles and other continuation bytes in between. It needs to be checked that the pulse fires and that only the low bits are taken. Directed sequences cover this and also cover the partial tone update. A long random byte stream then mostly sends continuation bytes, with bit 6 and the upper payload bits set at random, and drops strobes at random. This leaves selections in place across long gaps. The bench model checks all eight registers and the pulse after every cycle.

// File: rtl/psgr_pkg.sv
package psgr_pkg;
   // target selection held between bytes
   typedef struct packed {
      logic [1:0] chan;
      logic       is_att;
   } psgr_sel_t;

   localparam int BYTE_W     = 8;
   localparam int LO_FIELD_W = 4;   // payload width of a selecting byte
   localparam int HI_FIELD_W = 6;   // payload width of a continuation byte
   localparam int CHAN_W     = 2;
endpackage

// File: rtl/psgr_decode.sv
module psgr_decode
   import psgr_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int NUM_TONE = NUM_CH - 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic [NUM_CH-1:0]   att_we,
   output logic [NUM_TONE-1:0] tone_lo_we,
   output logic [NUM_TONE-1:0] tone_hi_we,
   output logic                noise_we
);
   psgr_sel_t sel_q;
   psgr_sel_t cur_sel;
   logic      is_select;

   assign is_select = wr_data[BYTE_W-1];

   always_comb begin
      if (is_select) begin
         cur_sel.chan   = wr_data[6:5];
         cur_sel.is_att = wr_data[4];
      end else begin
         cur_sel = sel_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= '0;
      end else if (wr_en && is_select) begin
         sel_q <= cur_sel;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_att_we
      assign att_we[c] = wr_en && cur_sel.is_att &&
                         (cur_sel.chan == CHAN_W'(c));
   end

   for (genvar t = 0; t < NUM_TONE; t++) begin : g_tone_we
      logic hit;
      assign hit           = wr_en && !cur_sel.is_att &&
                             (cur_sel.chan == CHAN_W'(t));
      assign tone_lo_we[t] = hit && is_select;
      assign tone_hi_we[t] = hit && !is_select;
   end

   assign noise_we = wr_en && !cur_sel.is_att &&
                     (cur_sel.chan == CHAN_W'(NUM_CH-1));
endmodule

// File: rtl/psgr_att_bank.sv
module psgr_att_bank
   import psgr_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ATT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_CH-1:0]       att_we,
   input  logic [BYTE_W-1:0]       wr_data,
   output logic [NUM_CH*ATT_W-1:0] att_flat
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_att
      logic [ATT_W-1:0] att_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            att_q <= '1;
         end else if (att_we[c]) begin
            att_q <= wr_data[ATT_W-1:0];
         end
      end
      assign att_flat[c*ATT_W +: ATT_W] = att_q;
   end
endmodule

// File: rtl/psgr_tone_bank.sv
module psgr_tone_bank
   import psgr_pkg::*;
#(
   parameter int NUM_TONE = 3,
   parameter int PERIOD_W = 10,
   localparam int UP_W = PERIOD_W - LO_FIELD_W
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_TONE-1:0]          tone_lo_we,
   input  logic [NUM_TONE-1:0]          tone_hi_we,
   input  logic [BYTE_W-1:0]            wr_data,
   output logic [NUM_TONE*PERIOD_W-1:0] tone_flat
);
   for (genvar t = 0; t < NUM_TONE; t++) begin : g_tone
      logic [LO_FIELD_W-1:0] lo_q;
      logic [UP_W-1:0]       up_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            lo_q <= '0;
         end else if (tone_lo_we[t]) begin
            lo_q <= wr_data[LO_FIELD_W-1:0];
         end
      end
      always_ff @(posedge clk) begin
         if (rst) begin
            up_q <= '0;
         end else if (tone_hi_we[t]) begin
            up_q <= wr_data[UP_W-1:0];
         end
      end
      assign tone_flat[t*PERIOD_W +: PERIOD_W] = {up_q, lo_q};
   end
endmodule

// File: rtl/psgr_noise_reg.sv
module psgr_noise_reg
   import psgr_pkg::*;
#(
   parameter int NOISE_W = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               noise_we,
   input  logic [BYTE_W-1:0]  wr_data,
   output logic [NOISE_W-1:0] noise_ctrl,
   output logic               noise_reset
);
   always_ff @(posedge clk) begin
      if (rst) begin
         noise_ctrl  <= '0;
         noise_reset <= 1'b0;
      end else begin
         noise_reset <= noise_we;
         if (noise_we) begin
            noise_ctrl <= wr_data[NOISE_W-1:0];
         end
      end
   end
endmodule

// File: rtl/psgr_regs.sv
module psgr_regs
   import psgr_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ATT_W    = 4,
   parameter int PERIOD_W = 10,
   parameter int NOISE_W  = 3,
   localparam int NUM_TONE = NUM_CH - 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [BYTE_W-1:0]             wr_data,
   output logic [NUM_CH*ATT_W-1:0]       att_flat,
   output logic [NUM_TONE*PERIOD_W-1:0]  tone_flat,
   output logic [NOISE_W-1:0]            noise_ctrl,
   output logic                          noise_reset
);
   // elaboration-time parameter checks
   if (NUM_CH != (1 << CHAN_W)) begin : g_bad_ch
      $error("NUM_CH must match the 2-bit channel field");
   end
   if (ATT_W < 1 || ATT_W > LO_FIELD_W) begin : g_bad_att
      $error("ATT_W must be 1..4");
   end
   if (PERIOD_W <= LO_FIELD_W || PERIOD_W > LO_FIELD_W + HI_FIELD_W) begin : g_bad_per
      $error("PERIOD_W must be 5..10");
   end
   if (NOISE_W < 1 || NOISE_W > LO_FIELD_W) begin : g_bad_noise
      $error("NOISE_W must be 1..4");
   end

   logic [NUM_CH-1:0]   att_we;
   logic [NUM_TONE-1:0] tone_lo_we;
   logic [NUM_TONE-1:0] tone_hi_we;
   logic                noise_we;

   psgr_decode #(.NUM_CH(NUM_CH)) u_decode (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .att_we     (att_we),
      .tone_lo_we (tone_lo_we),
      .tone_hi_we (tone_hi_we),
      .noise_we   (noise_we)
   );

   psgr_att_bank #(.NUM_CH(NUM_CH), .ATT_W(ATT_W)) u_att (
      .clk      (clk),
      .rst      (rst),
      .att_we   (att_we),
      .wr_data  (wr_data),
      .att_flat (att_flat)
   );

   psgr_tone_bank #(.NUM_TONE(NUM_TONE), .PERIOD_W(PERIOD_W)) u_tone (
      .clk        (clk),
      .rst        (rst),
      .tone_lo_we (tone_lo_we),
      .tone_hi_we (tone_hi_we),
      .wr_data    (wr_data),
      .tone_flat  (tone_flat)
   );

   psgr_noise_reg #(.NOISE_W(NOISE_W)) u_noise (
      .clk         (clk),
      .rst         (rst),
      .noise_we    (noise_we),
      .wr_data     (wr_data),
      .noise_ctrl  (noise_ctrl),
      .noise_reset (noise_reset)
   );
endmodule

// File: rtl/psgr_regs_chk.sv
module psgr_regs_chk
   import psgr_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ATT_W    = 4,
   parameter int PERIOD_W = 10,
   parameter int NOISE_W  = 3,
   localparam int NUM_TONE = NUM_CH - 1,
   localparam int NUM_REG  = NUM_CH + NUM_TONE + 1
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         wr_en,
   input logic [BYTE_W-1:0]            wr_data,
   input logic [NUM_CH*ATT_W-1:0]      att_flat,
   input logic [NUM_TONE*PERIOD_W-1:0] tone_flat,
   input logic [NOISE_W-1:0]           noise_ctrl,
   input logic                         noise_reset
);
   logic [NUM_CH*ATT_W-1:0]      att_prev;
   logic [NUM_TONE*PERIOD_W-1:0] tone_prev;
   logic [NOISE_W-1:0]           noise_prev;
   logic                         prev_ok;
   logic [NUM_REG-1:0]           chg;

   always_ff @(posedge clk) begin
      att_prev   <= att_flat;
      tone_prev  <= tone_flat;
      noise_prev <= noise_ctrl;
      prev_ok    <= !rst;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chg_att
      assign chg[c] = att_flat[c*ATT_W +: ATT_W] != att_prev[c*ATT_W +: ATT_W];
   end
   for (genvar t = 0; t < NUM_TONE; t++) begin : g_chg_tone
      assign chg[NUM_CH+t] = tone_flat[t*PERIOD_W +: PERIOD_W] !=
                             tone_prev[t*PERIOD_W +: PERIOD_W];
   end
   assign chg[NUM_REG-1] = noise_ctrl != noise_prev;

   // R10: one register at most moves per cycle
   a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
      prev_ok |-> $countones(chg) <= 1);

   // R9: idle strobe leaves everything alone
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(att_flat) && $stable(tone_flat) && $stable(noise_ctrl));

   // R8: pulse only after an accepted byte
   a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
      noise_reset |-> $past(wr_en));

   // R5: noise field moves only together with the pulse
   a_r5_noise_with_pulse: assert property (@(posedge clk) disable iff (rst)
      !$stable(noise_ctrl) |-> noise_reset);

   // R2: selecting byte for attenuation loads the addressed channel
   a_r2_select_att: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_data[7] && wr_data[4] |=>
         att_flat[$past(wr_data[6:5])*ATT_W +: ATT_W] == $past(wr_data[ATT_W-1:0]));

   // R3: continuation bytes never touch the low period bits
   for (genvar t = 0; t < NUM_TONE; t++) begin : g_lo_keep
      a_r3_low_kept: assert property (@(posedge clk) disable iff (rst)
         wr_en && !wr_data[7] |=> $stable(tone_flat[t*PERIOD_W +: LO_FIELD_W]));
   end
endmodule

bind psgr_regs psgr_regs_chk #(
   .NUM_CH(NUM_CH), .ATT_W(ATT_W), .PERIOD_W(PERIOD_W), .NOISE_W(NOISE_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
   .att_flat(att_flat), .tone_flat(tone_flat),
   .noise_ctrl(noise_ctrl), .noise_reset(noise_reset)
);

// File: tb/psgr_regs_tb.sv
module psgr_regs_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [7:0]  wr_data;
   logic [15:0] att_flat;
   logic [29:0] tone_flat;
   logic [2:0]  noise_ctrl;
   logic        noise_reset;

   int n_chk  = 0;
   int n_fail = 0;

   logic [3:0] m_att [4];
   logic [9:0] m_tone [3];
   logic [2:0] m_noise;
   logic [1:0] m_ch;
   logic       m_isatt;
   logic       m_pulse;
   int         m_tgt;   // 0..3 att, 4..6 tone, 7 noise, -1 none

   always #(CLK_PERIOD/2) clk = ~clk;

   psgr_regs u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .att_flat(att_flat), .tone_flat(tone_flat),
      .noise_ctrl(noise_ctrl), .noise_reset(noise_reset)
   );

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_att[i] = 4'hF;
      for (int i = 0; i < 3; i++) m_tone[i] = '0;
      m_noise = '0; m_ch = '0; m_isatt = 1'b0; m_pulse = 1'b0; m_tgt = -1;
   endtask

   task automatic model_write(input logic [7:0] b);
      if (b[7]) begin
         m_ch = b[6:5]; m_isatt = b[4];
      end
      if (m_isatt) begin
         m_att[m_ch] = b[3:0]; m_tgt = int'(m_ch);
      end else if (m_ch == 2'd3) begin
         m_noise = b[2:0]; m_tgt = 7;
      end else begin
         if (b[7]) m_tone[m_ch][3:0] = b[3:0];
         else      m_tone[m_ch][9:4] = b[5:0];
         m_tgt = 4 + int'(m_ch);
      end
      m_pulse = (!m_isatt && m_ch == 2'd3);
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < 4; i++)
         chk((m_tgt == i) ? tag : "R10", $sformatf("att%0d", i),
             32'(att_flat[i*4 +: 4]), 32'(m_att[i]));
      for (int i = 0; i < 3; i++)
         chk((m_tgt == 4+i) ? tag : "R10", $sformatf("tone%0d", i),
             32'(tone_flat[i*10 +: 10]), 32'(m_tone[i]));
      chk((m_tgt == 7) ? tag : "R10", "noise", 32'(noise_ctrl), 32'(m_noise));
      chk("R8", "noise_reset", 32'(noise_reset), 32'(m_pulse));
   endtask

   // one cycle: drive, pass an edge, update model, check
   task automatic step(input logic en, input logic [7:0] b);
      string tag;
      logic [1:0] ch;
      logic at;
      ch = b[7] ? b[6:5] : m_ch;
      at = b[7] ? b[4] : m_isatt;
      if (!en)             tag = "R9";
      else if (!at && ch == 2'd3) tag = "R5";
      else if (b[7])       tag = "R2";
      else if (at)         tag = "R4";
      else                 tag = "R3";
      wr_en = en; wr_data = b;
      @(negedge clk);
      m_tgt = -1; m_pulse = 1'b0;
      if (en) model_write(b);
      check_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681357));
      rst = 1'b1; wr_en = 1'b0; wr_data = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_all("R1");   // reset state

      // R7: partial tone value after a selecting byte alone
      step(1'b1, 8'b1000_1110);
      chk("R7", "tone0 partial", 32'(tone_flat[9:0]), 32'h00E);
      step(1'b1, 8'b0000_1111);
      chk("R3", "tone0 full", 32'(tone_flat[9:0]), 32'h0FE);
      // bit 6 of a continuation byte ignored
      step(1'b1, 8'b0111_0000);
      chk("R3", "tone0 bit6", 32'(tone_flat[9:0]), 32'h30E);

      // R4: attenuation select then continuation overrides it
      step(1'b1, 8'b1101_1111);
      step(1'b1, 8'b0011_0000);
      chk("R4", "att2 overwrite", 32'(att_flat[11:8]), 32'h0);

      // R5/R8: noise select then continuation, top payload bit dropped
      step(1'b1, 8'b1110_1101);
      chk("R5", "noise select", 32'(noise_ctrl), 32'h5);
      step(1'b0, 8'h00);
      chk("R8", "pulse drops", 32'(noise_reset), 32'h0);
      step(1'b1, 8'b0000_1100);
      chk("R5", "noise cont", 32'(noise_ctrl), 32'h4);

      // R6: selection survives idle cycles and repeated continuation bytes
      step(1'b1, 8'b1011_0011);
      repeat (5) step(1'b0, 8'hFF);
      step(1'b1, 8'b0000_0110);
      step(1'b1, 8'b0111_1001);
      chk("R6", "att1 repeated", 32'(att_flat[7:4]), 32'h9);

      // tone 2 upper bits, then a select to tone 2 keeps upper part
      step(1'b1, 8'b1100_0000);
      step(1'b1, 8'b0011_1111);
      step(1'b1, 8'b1100_0101);
      chk("R7", "tone2 mix", 32'(tone_flat[29:20]), 32'h3F5);

      // random stream, mostly continuation bytes
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] b;
         logic en;
         b  = 8'($urandom);
         b[7] = ($urandom % 4) == 0;
         en = ($urandom % 5) != 0;
         step(en, b);
      end

      // reset again mid-stream
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      check_all("R1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule